// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Early Stop

This block steps a successive-approximation conversion for an external DAC and comparator. A one-cycle convert request starts it. On the start edge it clears the result and sets the top bit as the first trial. On every later rising clock edge it settles one bit, working from the MSB down. A bit stays set when the comparator reports that the DAC output lies below the input, and is cleared otherwise. The following lower bit is then offered as the next trial. The trial code is driven to the DAC in true form throughout.

A busy flag is high for the whole conversion. It is produced on the falling clock edge, so every change of the result lands half a clock before the flag drops, and a consumer can latch the data on the flag's falling edge. An active-low stop input ends a conversion early. Wiring it to one of the result outputs gives 10-bit or 8-bit resolution, because that output goes low as soon as the bit below the last wanted one is offered as a trial. On the edge that samples the stop low, the pending trial bit is cleared and the conversion ends. Lower bits stay at zero.

The result pins are negative-true: a stored 1 is driven low. A unipolar result therefore reads as complementary straight binary. The MSB is also given in inverted form, so that taking it in place of the normal MSB turns a complementary offset-binary bipolar code into complementary two's complement.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is low, and after it is released, `dac_code` is all zeros, `status_o` is low, `res_n` is all ones and `msb_inv_n` is low. Reset in the middle of a conversion returns the block to this state.
- R2: A `conv_start` sampled high on a rising edge while idle loads `dac_code` with only the MSB set (0x800 for 12 bits). `status_o` rises on the following falling edge.
- R3: Each decision edge keeps the bit under trial if `cmp_keep` is 1 and clears it if `cmp_keep` is 0, then sets the next lower bit. With a comparator that reports `dac_code <= input`, a full conversion yields the input value.
- R4: With `stop_n` held high, all 12 bits are resolved. `status_o` is seen high after 12 consecutive rising edges (13 edges counting the start edge).
- R5: `res_n` is the bitwise complement of the resolved result (a stored 1 drives 0), and `dac_code` carries the same result in true form.
- R6: `msb_inv_n` equals the true MSB of the result. `{msb_inv_n, res_n[W-2:0]}` is therefore the complement of the result with its MSB inverted (complementary two's complement).
- R7: A `stop_n` sampled low on a rising edge while busy ends the conversion on that edge. With `stop_n` tied to `res_n[W-1-N]`, only the top N bits are resolved and `status_o` is seen high on N+1 rising edges (11 for N=10, 9 for N=8).
- R8: In an early-stopped conversion, every bit below the N resolved bits is 0 in `dac_code` and 1 in `res_n`, and so is the pending trial bit.
- R9: `res_n` holds its final value at the last rising edge on which `status_o` is still high. `status_o` falls on the next falling edge.
- R10: A `conv_start` that arrives while a conversion is running is ignored. The bit order, the conversion length and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; trials settle on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Convert request, sampled on rising edges while idle |
| stop_n | input | 1 | Active-low early stop, sampled on rising edges while busy |
| cmp_keep | input | 1 | Comparator: 1 when the DAC output is below the input |
| dac_code | output | W | Trial and result code to the DAC, true form |
| status_o | output | 1 | Busy flag, updated on falling edges |
| res_n | output | W | Negative-true result bits, MSB at index W-1 |
| msb_inv_n | output | 1 | Inverted form of the MSB result output |

## Verification
On every rising edge, the assertions check several rules. The bit under trial is never more than one bit. Bits below it are zero. A start loads only the MSB trial. A start during a conversion does not disturb the bit sequence. A stop clears the pending trial bit and ends the run. The busy flag agrees with the run state half a cycle later. Other behaviours can only be shown by the bench's scenarios against a modelled comparator: that the result equals the input value, the exact count of busy cycles for 12, 10 and 8 bits, the complementary and two's-complement codings, and the data being final before the flag falls.

// File: rtl/sarq_pkg.sv
package sarq_pkg;
  localparam int SARQ_DEF_BITS = 12;
endpackage

// File: rtl/sarq_core.sv
module sarq_core #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_req,
  input  logic         stop_n,
  input  logic         keep,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] cur_o,
  output logic         run_o,
  output logic         start_ev,
  output logic         stop_ev
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trial_q, cur_q;
  logic         run_q;
  logic         decide_ev;

  // settle the bit under trial, then offer the next lower one
  function automatic logic [W-1:0] settle(input logic [W-1:0] t,
                                          input logic [W-1:0] c,
                                          input logic k);
    logic [W-1:0] kept;
    kept = k ? c : '0;
    return (t & ~c) | kept | (c >> 1);
  endfunction

  assign start_ev  = start_req && !run_q;
  assign stop_ev   = run_q && !stop_n;
  assign decide_ev = run_q && stop_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      cur_q   <= '0;
      run_q   <= 1'b0;
    end else if (start_ev) begin
      trial_q <= TOP;
      cur_q   <= TOP;
      run_q   <= 1'b1;
    end else if (stop_ev) begin
      trial_q <= trial_q & ~cur_q;
      cur_q   <= '0;
      run_q   <= 1'b0;
    end else if (decide_ev) begin
      trial_q <= settle(trial_q, cur_q, keep);
      cur_q   <= cur_q >> 1;
      run_q   <= !cur_q[0];
    end
  end

  assign trial_o = trial_q;
  assign cur_o   = cur_q;
  assign run_o   = run_q;
endmodule

// File: rtl/sarq_status.sv
module sarq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic status_o
);
  // falling-edge copy: data settles half a cycle before the flag drops
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= run;
  end
endmodule

// File: rtl/sarq_drive.sv
module sarq_drive #(
  parameter int W = 12
) (
  input  logic [W-1:0] trial,
  output logic [W-1:0] res_n,
  output logic         msb_inv_n
);
  function automatic logic [W-1:0] neg_true(input logic [W-1:0] v);
    return ~v;
  endfunction

  assign res_n     = neg_true(trial);
  assign msb_inv_n = trial[W-1];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sarq_pkg::*;
#(
  parameter int W = SARQ_DEF_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic         stop_n,
  input  logic         cmp_keep,
  output logic [W-1:0] dac_code,
  output logic         status_o,
  output logic [W-1:0] res_n,
  output logic         msb_inv_n
);
  logic [W-1:0] trial, cur;
  logic         run, start_ev, stop_ev;

  sarq_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_req(conv_start), .stop_n(stop_n),
    .keep(cmp_keep), .trial_o(trial), .cur_o(cur), .run_o(run),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  sarq_status u_stat (
    .clk(clk), .rst_n(rst_n), .run(run), .status_o(status_o)
  );

  sarq_drive #(.W(W)) u_drv (
    .trial(trial), .res_n(res_n), .msb_inv_n(msb_inv_n)
  );

  assign dac_code = trial;
endmodule

// File: rtl/sarq_chk.sv
module sarq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_start,
  input logic         stop_n,
  input logic [W-1:0] dac_code,
  input logic         status_o,
  input logic [W-1:0] cur,
  input logic         run,
  input logic         start_ev,
  input logic         stop_ev
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R3
  one_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur));

  // R8
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dac_code & (cur - ONE)) == '0);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> run && dac_code == TOP && cur == TOP);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && conv_start && stop_n && !cur[0]) |=> run && cur == ($past(cur) >> 1));

  // R7
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !run && (dac_code & $past(cur)) == '0);

  // R9
  status_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == run);
endmodule

bind sar_sequencer sarq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .stop_n(stop_n),
  .dac_code(dac_code), .status_o(status_o), .cur(cur), .run(run),
  .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/sim_sar_sequencer.sv
`timescale 1ns/1ps
module sim_sar_sequencer;
  localparam int W = 12;
  localparam int NV = 10;
  // {input value, resolution}
  localparam logic [15:0] VEC [NV] = '{
    {12'h000, 4'd12}, {12'hFFF, 4'd12}, {12'h800, 4'd12}, {12'h7FF, 4'd12},
    {12'hA5A, 4'd12}, {12'h123, 4'd12}, {12'hA5A, 4'd10}, {12'hA5A, 4'd8},
    {12'hFFF, 4'd8},  {12'h003, 4'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0, conv_start = 1'b0;
  logic [W-1:0] vin = '0;
  int nb_sel = W;
  logic stop_n, cmp_keep, status_o, msb_inv_n;
  logic [W-1:0] dac_code, res_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // comparator and short-cycle wiring
  assign cmp_keep = (dac_code <= vin);
  assign stop_n   = (nb_sel >= W) ? 1'b1 : res_n[W-1-nb_sel];

  sar_sequencer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .stop_n(stop_n),
    .cmp_keep(cmp_keep), .dac_code(dac_code), .status_o(status_o),
    .res_n(res_n), .msb_inv_n(msb_inv_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_state(input string tag);
    chk(dac_code == '0, tag, dac_code, 0);
    chk(status_o == 1'b0, tag, status_o, 0);
    chk(res_n == '1, tag, res_n, 12'hFFF);
    chk(msb_inv_n == 1'b0, tag, msb_inv_n, 0);
  endtask

  task automatic convert(input logic [W-1:0] v, input int n, input bit poke);
    int hi;
    logic [W-1:0] last, exp;
    int exp_cnt;
    vin = v; nb_sel = n;
    @(negedge clk); conv_start = 1'b1;
    @(posedge clk); #1 conv_start = 1'b0;
    #1;
    chk(dac_code == 12'h800, "R2 first trial", dac_code, 12'h800);
    hi = 0; last = res_n;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      if (!status_o) break;
      hi++; last = res_n;
      conv_start = (poke && hi == 4);
    end
    conv_start = 1'b0;
    exp = v & ~((12'd1 << (W - n)) - 12'd1);
    exp_cnt = (n >= W) ? W : n + 1;
    if (n >= W) chk(hi == exp_cnt, poke ? "R10 length" : "R4 length", hi, exp_cnt);
    else        chk(hi == exp_cnt, "R7 length", hi, exp_cnt);
    chk(dac_code == exp, (n >= W) ? "R3 result" : "R8 low bits", dac_code, exp);
    chk(res_n == ~exp, "R5 negative-true", res_n, ~exp);
    chk({msb_inv_n, res_n[W-2:0]} == ~(exp ^ 12'h800), "R6 twos", {msb_inv_n, res_n[W-2:0]},
        ~(exp ^ 12'h800));
    chk(last == res_n, "R9 data before fall", last, res_n);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    idle_state("R1 in reset");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    idle_state("R1 after reset");
    for (int i = 0; i < NV; i++) convert(VEC[i][15:4], int'(VEC[i][3:0]), 1'b0);
    // start pulse in mid-conversion must be ignored
    convert(12'h5C3, 12, 1'b1);
    // R7 8-bit result with a value whose top bits clear
    convert(12'h0F7, 8, 1'b0);
    // R1 reset in the middle of a conversion
    vin = 12'hABC; nb_sel = W;
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; #1;
    idle_state("R1 mid reset");
    @(negedge clk); rst_n = 1'b1;
    convert(12'h3A0, 10, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule